// File: doc/BRIEF.md
# Flash Command Control Register Bank

This block is the software-facing register bank of a flash memory controller. It is written and read one byte at a time through a simple select/data bus. It holds a 13-bit flash address, split over a low byte and a high byte. It also holds a read-enable bit and three command bits, which start a read, a write or a write-buffer clear.

Each accepted command raises a one-cycle request towards the flash backend. Its command bit then stays set until the backend answers on the matching done input. Only hardware completion clears a command bit. Software polls the bit until it reads zero.

A separate pattern register resets the whole chip. Writing one magic byte to it produces a fixed-length, registered reset pulse.

Top module: `fcmd_regbank`

## Requirements
- R1: After reset every register reads 0x00, and `chip_rst`, `flash_rd_en`, `flash_addr` and the three request outputs are all 0.
- R2: Select 3 (address low) stores `flash_addr[7:0]`. Select 4 (address high) stores `flash_addr[12:8]` from data bits 4..0. Bits 7..5 of select 4 always read 0. `flash_addr` changes only on writes to these two selects.
- R3: Select 0 (control) reads read-start in bit 0, read-enable in bit 1, write-start in bit 2, and 0 in bits 7..3. Select 1 (buffer control) reads clear-start in bit 0 and 0 in bits 7..1. Selects 5..7 read 0x00. `flash_rd_en` follows the read-enable bit.
- R4: When a command bit goes from 0 to 1, the matching request output (`rd_req`, `wr_req` or `clr_req`) is high for exactly one cycle. That cycle is the first cycle in which the bit reads 1. No request is raised without such a start.
- R5: A command bit stays 1 until its own done input is sampled high. It reads 0 from the next cycle on. A done input for an operation that is not running has no effect.
- R6: A read start is accepted only when the read-enable bit written in the same control write is 1. Otherwise the read-start bit stays 0 and no `rd_req` is issued.
- R7: At most one command bit is set at any time. A start written while any operation is running is ignored. If one control write sets both read-start and write-start while idle, the read wins when it is enabled.
- R8: Writing 0 to a command bit while its operation is running leaves the bit at 1.
- R9: Writing 0x55 to select 2 (reset pattern) raises `chip_rst` for exactly 4 cycles, beginning the cycle after the write. The register reads 0x55 during the pulse and 0x00 after it. Writes to select 2 during the pulse are ignored.
- R10: Writing any other value to select 2 stores it so it reads back, and produces no reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_sel | input | 3 | Register select for writes |
| bus_wr_data | input | 8 | Write data |
| bus_rd_sel | input | 3 | Register select for read-back |
| bus_rd_data | output | 8 | Combinational read-back data |
| flash_addr | output | 13 | Flash address to the backend |
| flash_rd_en | output | 1 | Read-enable level to the backend |
| rd_req | output | 1 | One-cycle read request |
| wr_req | output | 1 | One-cycle write request |
| clr_req | output | 1 | One-cycle write-buffer clear request |
| rd_done | input | 1 | Backend read completion |
| wr_done | input | 1 | Backend write completion |
| clr_done | input | 1 | Backend buffer-clear completion |
| chip_rst | output | 1 | Whole-chip reset pulse |

## Verification
Every cycle, the embedded properties check the following:
- never more than one command bit is set;
- each request is a single-cycle pulse that coincides with its command bit, and a read request only goes out with reading enabled;
- a running command bit holds until its own done arrives;
- the address holds between writes;
- every reset pulse follows a write of the magic byte and lasts exactly the configured length.

Only the bench scenarios can show what cannot be checked from internal signals alone. These cover the read-back encodings and the zeroed unimplemented bits. They also cover the rejection of a disabled read start, the ignored starts and clearing writes while busy, and read-over-write priority. Two more cases need a scenario: a stray done for an idle operation, and a non-magic byte reading back without a reset.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam int SEL_W  = 3;
    localparam int DATA_W = 8;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 3'd0,
        SEL_BUF  = 3'd1,
        SEL_RST  = 3'd2,
        SEL_ADRL = 3'd3,
        SEL_ADRH = 3'd4
    } reg_sel_e;

    // bit positions inside the control and buffer registers
    localparam int CTRL_RD_GO = 0;
    localparam int CTRL_RD_EN = 1;
    localparam int CTRL_WR_GO = 2;
    localparam int BUF_CLR_GO = 0;

    typedef struct packed {
        logic rd_go;
        logic rd_en;
        logic wr_go;
        logic clr_go;
        logic rd_req;
        logic wr_req;
        logic clr_req;
    } cmd_state_t;

endpackage

// File: rtl/fcmd_addr.sv
module fcmd_addr #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [7:0]        wdata,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - 8;

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (lo_wr) addr_d[7:0] = wdata;
        if (hi_wr) addr_d[ADDR_W-1:8] = wdata[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_wr && !hi_wr) |=> $stable(addr));

endmodule

// File: rtl/fcmd_cmd.sv
module fcmd_cmd
    import fcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       buf_wr,
    input  logic [7:0] wdata,
    input  logic       rd_done,
    input  logic       wr_done,
    input  logic       clr_done,
    output logic       rd_go,
    output logic       rd_en,
    output logic       wr_go,
    output logic       clr_go,
    output logic       rd_req,
    output logic       wr_req,
    output logic       clr_req
);
    cmd_state_t st_d, st_q;
    logic       busy;

    always_comb begin
        st_d         = st_q;
        st_d.rd_req  = 1'b0;
        st_d.wr_req  = 1'b0;
        st_d.clr_req = 1'b0;
        busy = st_q.rd_go | st_q.wr_go | st_q.clr_go;

        if (st_q.rd_go  && rd_done)  st_d.rd_go  = 1'b0;
        if (st_q.wr_go  && wr_done)  st_d.wr_go  = 1'b0;
        if (st_q.clr_go && clr_done) st_d.clr_go = 1'b0;

        if (ctrl_wr) begin
            st_d.rd_en = wdata[CTRL_RD_EN];
            if (!busy) begin
                if (wdata[CTRL_RD_GO] && wdata[CTRL_RD_EN]) begin
                    st_d.rd_go  = 1'b1;
                    st_d.rd_req = 1'b1;
                end else if (wdata[CTRL_WR_GO]) begin
                    st_d.wr_go  = 1'b1;
                    st_d.wr_req = 1'b1;
                end
            end
        end else if (buf_wr && !busy && wdata[BUF_CLR_GO]) begin
            st_d.clr_go  = 1'b1;
            st_d.clr_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_go   = st_q.rd_go;
    assign rd_en   = st_q.rd_en;
    assign wr_go   = st_q.wr_go;
    assign clr_go  = st_q.clr_go;
    assign rd_req  = st_q.rd_req;
    assign wr_req  = st_q.wr_req;
    assign clr_req = st_q.clr_req;

    // R7
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_go, wr_go, clr_go}));

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_go && !$past(rd_go)) ##1 !rd_req);

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_go && !$past(wr_go)) ##1 !wr_req);

    // R4
    clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |-> (clr_go && !$past(clr_go)) ##1 !clr_req);

    // R6
    rd_req_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_en);

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !rd_done) |=> rd_go);

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !wr_done) |=> wr_go);

    // R5
    clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_go && !clr_done) |=> clr_go);

endmodule

// File: rtl/fcmd_rstgen.sv
module fcmd_rstgen #(
    parameter logic [7:0] PATTERN = 8'h55,
    parameter int         PULSE   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pat_wr,
    input  logic [7:0] wdata,
    output logic [7:0] pat,
    output logic       chip_rst
);
    localparam int CNT_W = $clog2(PULSE + 1);

    typedef struct packed {
        logic [7:0]       pat;
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } rg_t;

    rg_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (rg_q.cnt != '0) begin
            rg_d.cnt = rg_q.cnt - 1'b1;
            if (rg_q.cnt == CNT_W'(1)) rg_d.pat = '0;
        end else if (pat_wr) begin
            rg_d.pat = wdata;
            if (wdata == PATTERN) rg_d.cnt = CNT_W'(PULSE);
        end
        rg_d.pulse = (rg_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign pat      = rg_q.pat;
    assign chip_rst = rg_q.pulse;

    // length monitor for the reset pulse
    logic [CNT_W:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_q <= '0;
        else if (chip_rst) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    // R9
    rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_rst) |-> $past(pat_wr && wdata == PATTERN));

    // R9
    rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chip_rst) |-> (run_q == (CNT_W+1)'(PULSE) && pat == '0));

endmodule

// File: rtl/fcmd_regbank.sv
module fcmd_regbank
    import fcmd_pkg::*;
#(
    parameter int         ADDR_W    = 13,
    parameter logic [7:0] RST_MAGIC = 8'h55,
    parameter int         RST_LEN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [2:0]        bus_wr_sel,
    input  logic [7:0]        bus_wr_data,
    input  logic [2:0]        bus_rd_sel,
    output logic [7:0]        bus_rd_data,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_rd_en,
    output logic              rd_req,
    output logic              wr_req,
    output logic              clr_req,
    input  logic              rd_done,
    input  logic              wr_done,
    input  logic              clr_done,
    output logic              chip_rst
);
    localparam int HI_W = ADDR_W - 8;

    logic ctrl_wr, buf_wr, pat_wr, lo_wr, hi_wr;
    logic rd_go, wr_go, clr_go, rd_en;
    logic [7:0] pat;

    always_comb begin
        ctrl_wr = bus_wr_en && (bus_wr_sel == SEL_CTRL);
        buf_wr  = bus_wr_en && (bus_wr_sel == SEL_BUF);
        pat_wr  = bus_wr_en && (bus_wr_sel == SEL_RST);
        lo_wr   = bus_wr_en && (bus_wr_sel == SEL_ADRL);
        hi_wr   = bus_wr_en && (bus_wr_sel == SEL_ADRH);
    end

    fcmd_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .buf_wr   (buf_wr),
        .wdata    (bus_wr_data),
        .rd_done  (rd_done),
        .wr_done  (wr_done),
        .clr_done (clr_done),
        .rd_go    (rd_go),
        .rd_en    (rd_en),
        .wr_go    (wr_go),
        .clr_go   (clr_go),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .clr_req  (clr_req)
    );

    fcmd_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .lo_wr (lo_wr),
        .hi_wr (hi_wr),
        .wdata (bus_wr_data),
        .addr  (flash_addr)
    );

    fcmd_rstgen #(.PATTERN(RST_MAGIC), .PULSE(RST_LEN)) u_rstgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .pat_wr   (pat_wr),
        .wdata    (bus_wr_data),
        .pat      (pat),
        .chip_rst (chip_rst)
    );

    assign flash_rd_en = rd_en;

    always_comb begin
        bus_rd_data = '0;
        case (bus_rd_sel)
            SEL_CTRL: begin
                bus_rd_data[CTRL_RD_GO] = rd_go;
                bus_rd_data[CTRL_RD_EN] = rd_en;
                bus_rd_data[CTRL_WR_GO] = wr_go;
            end
            SEL_BUF:  bus_rd_data[BUF_CLR_GO] = clr_go;
            SEL_RST:  bus_rd_data = pat;
            SEL_ADRL: bus_rd_data = flash_addr[7:0];
            SEL_ADRH: bus_rd_data[HI_W-1:0] = flash_addr[ADDR_W-1:8];
            default:  bus_rd_data = '0;
        endcase
    end

endmodule

// File: tb/tb_fcmd_regbank.sv
`timescale 1ns/1ps
module tb_fcmd_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [2:0]  bus_wr_sel = '0;
    logic [7:0]  bus_wr_data = '0;
    logic [2:0]  bus_rd_sel = '0;
    logic [7:0]  bus_rd_data;
    logic [12:0] flash_addr;
    logic        flash_rd_en, rd_req, wr_req, clr_req, chip_rst;
    logic        rd_done = 1'b0, wr_done = 1'b0, clr_done = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int exp_q[$];   // expected request kinds: 0 read, 1 write, 2 clear

    always #2 clk = ~clk;

    fcmd_regbank dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(bus_wr_en), .bus_wr_sel(bus_wr_sel), .bus_wr_data(bus_wr_data),
        .bus_rd_sel(bus_rd_sel), .bus_rd_data(bus_rd_data),
        .flash_addr(flash_addr), .flash_rd_en(flash_rd_en),
        .rd_req(rd_req), .wr_req(wr_req), .clr_req(clr_req),
        .rd_done(rd_done), .wr_done(wr_done), .clr_done(clr_done),
        .chip_rst(chip_rst)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(string tag, logic [2:0] sel, logic [7:0] exp);
        bus_rd_sel = sel;
        #1;
        chk(tag, 16'(bus_rd_data), 16'(exp));
    endtask

    // driver: performs a bus write and records any request it should cause
    task automatic bus_write(logic [2:0] sel, logic [7:0] data, int exp_kind);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_wr_sel = sel; bus_wr_data = data;
        if (exp_kind >= 0) exp_q.push_back(exp_kind);
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic pulse_done(int kind);
        @(negedge clk);
        rd_done = (kind == 0); wr_done = (kind == 1); clr_done = (kind == 2);
        @(posedge clk);
        @(negedge clk);
        rd_done = 1'b0; wr_done = 1'b0; clr_done = 1'b0;
    endtask

    // monitor: every request pulse must match the next expected item (R4)
    always @(negedge clk) begin
        if (rst_n && (rd_req || wr_req || clr_req)) begin
            int got;
            got = rd_req ? 0 : (wr_req ? 1 : 2);
            chk("R4 request count", 16'($countones({rd_req, wr_req, clr_req})), 16'd1);
            if (exp_q.size() == 0) begin
                chk("R4 unexpected request", 16'(got), 16'hFFFF);
            end else begin
                chk("R4 request kind", 16'(got), 16'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 8; s++) chk_reg("R1 reset readback", 3'(s), 8'h00);
        chk("R1 reset outputs", {chip_rst, flash_rd_en, rd_req, wr_req, clr_req, flash_addr},
            16'h0000);

        // R2 address split and unimplemented high bits
        bus_write(3'd3, 8'hA5, -1);
        bus_write(3'd4, 8'hFF, -1);
        chk_reg("R2 addr high", 3'd4, 8'h1F);
        chk_reg("R2 addr low", 3'd3, 8'hA5);
        chk("R2 flash_addr", 16'(flash_addr), 16'h1FA5);
        repeat (3) @(negedge clk);
        chk("R2 addr held", 16'(flash_addr), 16'h1FA5);

        // R6 read start without enable is dropped
        bus_write(3'd0, 8'h01, -1);
        chk_reg("R6 disabled read start", 3'd0, 8'h00);

        // R3 R4 enabled read start
        bus_write(3'd0, 8'h03, 0);
        chk_reg("R3 ctrl readback", 3'd0, 8'h03);
        chk("R3 flash_rd_en", 16'(flash_rd_en), 16'd1);

        // R8 clearing the start bit while busy has no effect
        bus_write(3'd0, 8'h02, -1);
        chk_reg("R8 clear while busy", 3'd0, 8'h03);

        // R7 starts while busy are ignored
        bus_write(3'd0, 8'h06, -1);
        chk_reg("R7 write start while busy", 3'd0, 8'h03);
        bus_write(3'd1, 8'h01, -1);
        chk_reg("R7 clear start while busy", 3'd1, 8'h00);

        // R5 wrong done is ignored, own done clears
        pulse_done(1);
        chk_reg("R5 foreign done ignored", 3'd0, 8'h03);
        pulse_done(0);
        chk_reg("R5 read done clears", 3'd0, 8'h02);

        // write command
        bus_write(3'd0, 8'h04, 1);
        chk_reg("R3 write start readback", 3'd0, 8'h04);
        chk("R3 flash_rd_en off", 16'(flash_rd_en), 16'd0);
        pulse_done(1);
        chk_reg("R5 write done clears", 3'd0, 8'h00);

        // buffer clear command, upper bits read zero
        bus_write(3'd1, 8'hFF, 2);
        chk_reg("R3 buffer readback", 3'd1, 8'h01);
        pulse_done(2);
        chk_reg("R5 clear done clears", 3'd1, 8'h00);

        // R7 read wins over write in one control write
        bus_write(3'd0, 8'h07, 0);
        chk_reg("R7 read priority", 3'd0, 8'h03);
        pulse_done(0);
        chk_reg("R5 read done again", 3'd0, 8'h02);

        // R10 non-magic pattern
        bus_write(3'd2, 8'h54, -1);
        chk_reg("R10 pattern readback", 3'd2, 8'h54);
        for (int i = 0; i < 5; i++) begin
            chk("R10 no reset", 16'(chip_rst), 16'd0);
            @(negedge clk);
        end

        // R9 magic pattern: reset for exactly four cycles
        @(negedge clk);
        bus_wr_en = 1'b1; bus_wr_sel = 3'd2; bus_wr_data = 8'h55;
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
        chk_reg("R9 pattern during pulse", 3'd2, 8'h55);
        for (int i = 0; i < 4; i++) begin
            chk("R9 reset high", 16'(chip_rst), 16'd1);
            if (i == 1) begin
                bus_wr_en = 1'b1; bus_wr_sel = 3'd2; bus_wr_data = 8'h12;
            end else begin
                bus_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        bus_wr_en = 1'b0;
        chk("R9 reset ends", 16'(chip_rst), 16'd0);
        chk_reg("R9 pattern cleared", 3'd2, 8'h00);

        repeat (4) @(negedge clk);
        chk("R4 all requests seen", 16'(exp_q.size()), 16'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule